// File: doc/BRIEF.md
# Packet Interrupt Coalescing Unit

This unit serves one direction of a scatter-gather DMA channel. Each finished packet bumps a count of packets that software has not yet handled. Instead of interrupting once per packet, the unit raises its interrupt line in batches. An interrupt comes either when the backlog reaches a programmed threshold, or when packets have waited too long, measured in millisecond ticks supplied from outside. End-of-list and bus-error pulses are latched as separate status causes.

Software works through a small register port:

| Address | Register | Access |
|---|---|---|
| 0 | Threshold | read/write |
| 1 | Wait bound | read/write |
| 2 | Backlog count | read; a write decrements |
| 3 | Status | read; a write toggles |
| 4 | Enable mask | read/write |

After servicing a packet, software decrements the backlog. It acknowledges causes by writing back the status value it read: each 1 written flips that status bit rather than clearing it.

Top module: `pkt_coalesce_top`

## Requirements
- R1: A synchronous reset clears the backlog count, status, threshold, wait bound, enable mask and timer, so the interrupt line is low.
- R2: Each cycle with `pkt_done_i` high and no decrement raises the backlog count by one. At 255 (the all-ones value of the 8-bit count) it holds instead of wrapping.
- R3: A write to address 2 lowers the backlog count by one. At zero the write has no effect. A decrement and a packet in the same cycle leave the count unchanged.
- R4: The 8-bit threshold (address 0) and the 10-bit wait bound (address 1) accept writes only while `chan_run_i` is low. Writes made while it is high are ignored.
- R5: Status bit 1 (threshold) sets in the cycle after the count is at or above a nonzero threshold. If the count is still at or above the threshold when the bit is acknowledged, it stays set.
- R6: A threshold of 0 never sets status bit 1, however large the count.
- R7: While the count is nonzero, a timer counts millisecond ticks. It restarts from zero on each packet and whenever the count is zero. On the tick that reaches a nonzero wait bound it sets status bit 2, provided the threshold is 0 or the count is below it, and then restarts. A wait bound of 0 never sets bit 2.
- R8: A `bus_err_i` pulse sets status bit 0. An `sg_end_i` pulse sets status bit 3.
- R9: A write to address 3 flips every status bit whose written bit (3:0) is 1, so writing a 1 to a clear bit sets it. A set event in the same cycle takes precedence over the flip.
- R10: `irq_o` is high exactly when some status bit and the matching bit of the enable mask (address 4, bits 3:0) are both 1.
- R11: After a reset, writing back a status value read before the reset sets exactly those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_run_i | input | 1 | Channel started; locks threshold and wait bound |
| pkt_done_i | input | 1 | One-cycle pulse per completed packet |
| sg_end_i | input | 1 | One-cycle pulse at end of descriptor list |
| bus_err_i | input | 1 | One-cycle pulse on DMA bus error |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The backlog is first grown one packet at a time past a threshold of 3. This separates an early or late threshold flag from a correct one. It also shows whether an acknowledge given before the decrement re-arms, and one given after it clears. Tick trains of three and four, with and without a packet in between, separate a timer that restarts on packets from one that keeps running, and a bound of zero from a live bound. Long packet bursts and packets coinciding with decrements separate saturation from wrap and a simultaneous increment and decrement from either one alone. A status value captured before a reset and written back after it shows that acknowledges toggle rather than clear.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int ADDR_W = 3;
    localparam int ST_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_THR  = 3'd0,
        SEL_WAIT = 3'd1,
        SEL_CNT  = 3'd2,
        SEL_STAT = 3'd3,
        SEL_EN   = 3'd4
    } reg_sel_e;

    // bit 3 .. bit 0
    typedef struct packed {
        logic sg_end;
        logic wait_exp;
        logic thr_hit;
        logic dma_err;
    } status_t;

    function automatic status_t to_status(input logic [ST_W-1:0] v);
        return status_t'(v);
    endfunction

    function automatic logic sel_is(input logic [ADDR_W-1:0] a, input reg_sel_e s);
        return a == s;
    endfunction

endpackage

// File: rtl/pcu_pkt_counter.sv
module pcu_pkt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc_i && !dec_i) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else if (dec_i && !inc_i) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    p_sat_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && inc_i && !dec_i) |=> cnt_q == CNT_MAX);
    p_dec_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && dec_i && !inc_i) |=> cnt_q == '0);
    p_both_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (inc_i && dec_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pcu_wait_timer.sv
module pcu_wait_timer #(
    parameter int WB_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pending_i,
    input  logic            restart_i,
    input  logic            tick_i,
    input  logic            below_thr_i,
    input  logic [WB_W-1:0] bound_i,
    output logic            expire_o
);
    localparam logic [WB_W-1:0] WT_MAX = '1;

    logic [WB_W-1:0] wt_q;
    logic            at_last;

    assign at_last  = (bound_i != '0) && (wt_q == bound_i - 1'b1);
    assign expire_o = pending_i && !restart_i && tick_i && at_last && below_thr_i;

    always_ff @(posedge clk) begin
        if (rst || !pending_i || restart_i) begin
            wt_q <= '0;
        end else if (tick_i) begin
            if (at_last)              wt_q <= '0;
            else if (wt_q != WT_MAX)  wt_q <= wt_q + 1'b1;
        end
    end

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> wt_q == '0);
    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (pending_i && !restart_i && !tick_i) |=> $stable(wt_q));

endmodule

// File: rtl/pcu_status_reg.sv
module pcu_status_reg
    import pcu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  status_t set_i,
    input  status_t tog_i,
    output status_t st_o
);
    status_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= (st_q ^ tog_i) | set_i;
    end

    assign st_o = st_q;

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set_i.thr_hit |=> st_q.thr_hit);
    p_err_latch_r8: assert property (@(posedge clk) disable iff (rst)
        set_i.dma_err |=> st_q.dma_err);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (set_i == '0 && tog_i == '0) |=> $stable(st_q));

endmodule

// File: rtl/pkt_coalesce_top.sv
module pkt_coalesce_top
    import pcu_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WB_W   = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_run_i,
    input  logic              pkt_done_i,
    input  logic              sg_end_i,
    input  logic              bus_err_i,
    input  logic              ms_tick_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] thr_q;
    logic [WB_W-1:0]  wb_q;
    logic [ST_W-1:0]  en_q;
    logic [CNT_W-1:0] cnt;
    logic             dec, cfg_ok, thr_hit, below_thr, expire;
    status_t          set_v, tog_v, st;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata_i;
    assign dec    = reg_wr_i && sel_is(reg_addr_i, SEL_CNT);
    assign cfg_ok = reg_wr_i && !chan_run_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            wb_q  <= '0;
            en_q  <= '0;
        end else begin
            if (cfg_ok && sel_is(reg_addr_i, SEL_THR))  thr_q <= reg_wdata_i[CNT_W-1:0];
            if (cfg_ok && sel_is(reg_addr_i, SEL_WAIT)) wb_q  <= reg_wdata_i[WB_W-1:0];
            if (reg_wr_i && sel_is(reg_addr_i, SEL_EN)) en_q  <= reg_wdata_i[ST_W-1:0];
        end
    end

    pcu_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc_i(pkt_done_i), .dec_i(dec), .cnt_o(cnt)
    );

    assign thr_hit   = (thr_q != '0) && (cnt >= thr_q);
    assign below_thr = (thr_q == '0) || (cnt < thr_q);

    pcu_wait_timer #(.WB_W(WB_W)) u_tmr (
        .clk(clk), .rst(rst), .pending_i(cnt != '0), .restart_i(pkt_done_i),
        .tick_i(ms_tick_i), .below_thr_i(below_thr), .bound_i(wb_q),
        .expire_o(expire)
    );

    always_comb begin
        set_v          = '0;
        set_v.dma_err  = bus_err_i;
        set_v.thr_hit  = thr_hit;
        set_v.wait_exp = expire;
        set_v.sg_end   = sg_end_i;
        tog_v = (reg_wr_i && sel_is(reg_addr_i, SEL_STAT))
              ? to_status(reg_wdata_i[ST_W-1:0]) : '0;
    end

    pcu_status_reg u_st (
        .clk(clk), .rst(rst), .set_i(set_v), .tog_i(tog_v), .st_o(st)
    );

    assign irq_o = |(st & en_q);

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            SEL_THR:  reg_rdata_o[CNT_W-1:0] = thr_q;
            SEL_WAIT: reg_rdata_o[WB_W-1:0]  = wb_q;
            SEL_CNT:  reg_rdata_o[CNT_W-1:0] = cnt;
            SEL_STAT: reg_rdata_o[ST_W-1:0]  = st;
            SEL_EN:   reg_rdata_o[ST_W-1:0]  = en_q;
            default:  reg_rdata_o = '0;
        endcase
    end

    p_cfg_locked_r4: assert property (@(posedge clk) disable iff (rst)
        chan_run_i |=> ($stable(thr_q) && $stable(wb_q)));
    p_thr_off_r6: assert property (@(posedge clk) disable iff (rst)
        (thr_q == '0 && !(reg_wr_i && sel_is(reg_addr_i, SEL_STAT)) && !st.thr_hit)
        |=> !st.thr_hit);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (st == '0 && cnt == '0 && !irq_o));

endmodule

// File: tb/tb_pkt_coalesce_top.sv
module tb_pkt_coalesce_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        chan_run_i = 0, pkt_done_i = 0, sg_end_i = 0, bus_err_i = 0, ms_tick_i = 0;
    logic        reg_wr_i = 0;
    logic [2:0]  reg_addr_i = 0;
    logic [15:0] reg_wdata_i = 0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0, errors = 0, cycles = 0;
    bit cmp_on = 0;

    // behavioural reference state
    int m_cnt, m_thr, m_wb, m_wt, m_st, m_en;

    always #10 clk = ~clk;

    pkt_coalesce_top dut (
        .clk(clk), .rst(rst), .chan_run_i(chan_run_i), .pkt_done_i(pkt_done_i),
        .sg_end_i(sg_end_i), .bus_err_i(bus_err_i), .ms_tick_i(ms_tick_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_read(input int a);
        case (a)
            0: return m_thr;
            1: return m_wb;
            2: return m_cnt;
            3: return m_st;
            4: return m_en;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int tog, set_m;
        bit dec, hit, below, expire;
        if (rst) begin
            m_cnt = 0; m_thr = 0; m_wb = 0; m_wt = 0; m_st = 0; m_en = 0;
        end else begin
            dec    = reg_wr_i && reg_addr_i == 2;
            hit    = m_thr != 0 && m_cnt >= m_thr;
            below  = m_thr == 0 || m_cnt < m_thr;
            expire = m_cnt != 0 && !pkt_done_i && ms_tick_i && m_wb != 0 && m_wt == m_wb - 1 && below;
            if (m_cnt == 0 || pkt_done_i) m_wt = 0;
            else if (ms_tick_i) begin
                if (m_wb != 0 && m_wt == m_wb - 1) m_wt = 0;
                else if (m_wt < 1023) m_wt = m_wt + 1;
            end
            tog   = (reg_wr_i && reg_addr_i == 3) ? int'(reg_wdata_i & 16'hF) : 0;
            set_m = (bus_err_i ? 1 : 0) | (hit ? 2 : 0) | (expire ? 4 : 0) | (sg_end_i ? 8 : 0);
            m_st  = (m_st ^ tog) | set_m;
            if (pkt_done_i && !dec) begin if (m_cnt < 255) m_cnt++; end
            else if (dec && !pkt_done_i && m_cnt > 0) m_cnt--;
            if (reg_wr_i && !chan_run_i && reg_addr_i == 0) m_thr = reg_wdata_i & 16'hFF;
            if (reg_wr_i && !chan_run_i && reg_addr_i == 1) m_wb  = reg_wdata_i & 16'h3FF;
            if (reg_wr_i && reg_addr_i == 4) m_en = reg_wdata_i & 16'hF;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("MODEL rdata", int'(reg_rdata_o), m_read(int'(reg_addr_i)));
            chk("MODEL R10 irq", int'(irq_o), ((m_st & m_en) != 0) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input bit pkt, input bit sge, input bit berr, input bit tk,
                         input bit we, input int addr, input int data);
        pkt_done_i = pkt; sg_end_i = sge; bus_err_i = berr; ms_tick_i = tk;
        reg_wr_i = we; reg_addr_i = 3'(addr); reg_wdata_i = 16'(data);
        @(negedge clk); #2;
        pkt_done_i = 0; sg_end_i = 0; bus_err_i = 0; ms_tick_i = 0; reg_wr_i = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, int'(reg_addr_i), 0);
    endtask
    task automatic wr(input int addr, input int data);
        drive(0, 0, 0, 0, 1, addr, data);
    endtask
    task automatic pkt(input int n);
        for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, int'(reg_addr_i), 0);
    endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 1, 0, int'(reg_addr_i), 0);
    endtask
    task automatic rd(input int addr, output int v);
        reg_addr_i = 3'(addr); #1; v = int'(reg_rdata_o);
    endtask
    task automatic do_reset();
        rst = 1; idle(3); rst = 0;
    endtask

    initial begin
        int v;
        @(negedge clk); #2;
        do_reset();
        cmp_on = 1;
        rd(3, v); chk("R1 status after reset", v, 0);
        rd(2, v); chk("R1 count after reset", v, 0);
        chk("R1 irq after reset", int'(irq_o), 0);

        wr(0, 3); wr(1, 4); wr(4, 15);
        rd(0, v); chk("R4 threshold write while stopped", v, 3);
        chan_run_i = 1;
        wr(0, 9); wr(1, 7);
        rd(0, v); chk("R4 threshold locked while running", v, 3);
        rd(1, v); chk("R4 wait bound locked while running", v, 4);

        pkt(2); idle(2);
        rd(3, v); chk("R5 below threshold", v & 2, 0);
        pkt(1); idle(2);
        rd(2, v); chk("R2 count three", v, 3);
        rd(3, v); chk("R5 threshold bit set", v & 2, 2);
        chk("R10 irq on threshold", int'(irq_o), 1);
        wr(3, 2); idle(1);
        rd(3, v); chk("R5 reasserts when ack before decrement", v & 2, 2);
        wr(2, 0); wr(3, 2); idle(1);
        rd(3, v); chk("R9 ack after decrement clears", v & 2, 0);
        rd(2, v); chk("R3 decrement", v, 2);

        ticks(3);
        rd(3, v); chk("R7 no expiry before bound", v & 4, 0);
        ticks(1);
        rd(3, v); chk("R7 expiry at bound", v & 4, 4);
        wr(2, 0); wr(3, 4);
        ticks(3); pkt(1); ticks(3);
        rd(3, v); chk("R7 packet restarts timer", v & 4, 0);
        ticks(1);
        rd(3, v); chk("R7 expiry after restart", v & 4, 4);

        chan_run_i = 0;
        wr(1, 0); wr(3, 4); ticks(10);
        rd(3, v); chk("R7 wait bound zero disables", v & 4, 0);

        wr(0, 0); pkt(3); idle(2);
        rd(2, v); chk("R2 count five", v, 5);
        rd(3, v); chk("R6 threshold zero disables", v & 2, 0);

        wr(4, 0);
        drive(0, 0, 1, 0, 0, 3, 0);
        drive(0, 1, 0, 0, 0, 3, 0);
        idle(1);
        rd(3, v); chk("R8 error and end bits", v, 9);
        chk("R10 masked irq", int'(irq_o), 0);
        wr(4, 8); idle(1);
        chk("R10 enabled end bit irq", int'(irq_o), 1);
        wr(4, 4); idle(1);
        chk("R10 enable on clear bit", int'(irq_o), 0);
        wr(3, 4); idle(1);
        rd(3, v); chk("R9 toggle sets clear bit", v, 13);

        do_reset();
        rd(3, v); chk("R1 status cleared", v, 0);
        rd(2, v); chk("R1 count cleared", v, 0);
        wr(3, 13); idle(1);
        rd(3, v); chk("R11 stale write-back asserts bits", v, 13);
        chk("R11 irq stays low with mask cleared", int'(irq_o), 0);

        wr(2, 0);
        rd(2, v); chk("R3 decrement at zero", v, 0);
        drive(1, 0, 0, 0, 1, 2, 0);
        rd(2, v); chk("R3 simultaneous at zero", v, 0);
        pkt(300);
        rd(2, v); chk("R2 saturates", v, 255);
        drive(1, 0, 0, 0, 1, 2, 0);
        rd(2, v); chk("R3 simultaneous at max", v, 255);
        wr(2, 0);
        rd(2, v); chk("R3 decrement from max", v, 254);
        idle(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule